// File: doc/BRIEF.md
# Dual-Channel Disk Adapter Configuration and Address Decoder

This block is the front end of a two-channel disk adapter on a card-slot bus. It holds a small file of eight option bytes. Two of these bytes always return the adapter identity. The rest are written by configuration software. From these bytes the block derives, with no software sequencing, four things: the I/O windows of each channel, the interrupt number each channel drives, a 16 KB option ROM window in the upper memory area, and one master enable for the whole card.

On every clock the block compares the presented I/O address and memory address against these windows. It then registers a chip select for each channel's eight-byte command block, a select for each channel's single control register, and a select for the ROM window. The register file behind the selects, the ROM contents, and the drive protocol sit in neighbouring blocks. Per channel, the interrupt number and a valid flag are given to external steering logic.

Top module: `ide_cfg_decode`

## Requirements
- R1: Option byte offsets 0 and 1 always read 0xF1 and 0x71 respectively; writes to offsets 0 and 1 change nothing.
- R2: A write to any offset 2..7 stores the data byte, and a read of any offset returns the stored byte; the read data is combinational from the offset and the stored byte.
- R3: Byte 2 bit 0 is the card enable and is driven on `card_on`; while it is 0, no command, control or ROM select is asserted.
- R4: With the card enabled and byte 2 bit 7 set, `rom_cs` asserts for memory addresses in the 16 KB window at 0xC0000 + n*0x4000, where n is byte 2 bits 6:4 for n = 0..6; code 7 selects the same window as code 6 (0xD8000).
- R5: Byte 3 sets up the primary channel. Bit 3 is its I/O enable. Bits 1:0 choose the command base and control address: 0 gives 0x1F0/0x3F6, 1 gives 0x170/0x376, 2 gives 0x1E8/0x3EE, and 3 gives 0x168/0x36E. With the card and the channel both enabled, `pri_cmd_cs` covers base through base+7 and `pri_ctl_cs` covers only the control address.
- R6: For each channel, bit 7 of its byte is the interrupt enable, driven on the valid flag. Bits 5:4 map to IRQ 10, 11, 14 or 15 for codes 0..3. While bit 7 is 0, the valid flag and the IRQ number are both 0.
- R7: Byte 4 sets up the secondary channel with the same bit layout as byte 3. It drives `sec_cmd_cs`, `sec_ctl_cs`, `sec_irq` and `sec_irq_vld`.
- R8: A configuration write takes effect at the clock edge that samples it. Selects are registered: a select in the cycle after edge t reflects the addresses and the configuration held just before edge t. An access in the same cycle as an enabling write is therefore not yet selected.
- R9: Reset (`rst_n` low) clears bytes 2..7 to zero and drops every select and interrupt valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| cfg_wr | input | 1 | Option byte write strobe |
| cfg_addr | input | 3 | Option byte offset for read and write |
| cfg_wdata | input | 8 | Option byte write data |
| cfg_rdata | output | 8 | Option byte at `cfg_addr` |
| card_on | output | 1 | Card enable feedback (byte 2 bit 0) |
| io_addr | input | 16 | I/O address being decoded |
| mem_addr | input | 20 | Memory address being decoded |
| pri_cmd_cs | output | 1 | Primary command block select, registered |
| pri_ctl_cs | output | 1 | Primary control register select, registered |
| sec_cmd_cs | output | 1 | Secondary command block select, registered |
| sec_ctl_cs | output | 1 | Secondary control register select, registered |
| rom_cs | output | 1 | Option ROM window select, registered |
| pri_irq | output | 4 | Primary interrupt number |
| pri_irq_vld | output | 1 | Primary interrupt routed |
| sec_irq | output | 4 | Secondary interrupt number |
| sec_irq_vld | output | 1 | Secondary interrupt routed |

## Verification
Every base code of each channel is driven with one set of I/O addresses. The set covers the edges of all four command blocks (base-1, base, base+7, base+8) and every control address. This shows whether a decoder hit the wrong pair, missed an edge, or matched a neighbouring channel's window. All eight ROM codes are driven with addresses just inside and just outside the chosen window. This sets the code 7 alias apart from an off-by-one window. The same patterns are repeated with the card enable, channel enable or ROM enable cleared, and with a write and an access in the same cycle. These cases show the gating and the one-edge latency.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    localparam logic [7:0] CARD_ID_LO = 8'hF1;
    localparam logic [7:0] CARD_ID_HI = 8'h71;

    // field positions inside the option bytes
    localparam int CARD_EN_BIT = 0;
    localparam int ROM_EN_BIT  = 7;
    localparam int ROM_SEL_LSB = 4;
    localparam int CH_IO_EN    = 3;
    localparam int CH_IRQ_EN   = 7;
    localparam int CH_IRQ_LSB  = 4;

    localparam logic [15:0] CTL_OFFSET = 16'h0206;

    // command base: 0x1F0 stepped down by 0x80 (sel bit 0) and 0x08 (sel bit 1)
    function automatic logic [15:0] cmd_base(input logic [1:0] sel);
        return 16'h01F0 - (sel[0] ? 16'h0080 : 16'h0000) - (sel[1] ? 16'h0008 : 16'h0000);
    endfunction

    function automatic logic [15:0] ctl_addr(input logic [1:0] sel);
        return cmd_base(sel) + CTL_OFFSET;
    endfunction

    // 10, 11, 14, 15
    function automatic logic [3:0] irq_of(input logic [1:0] sel);
        return 4'd10 + {1'b0, sel[1], 1'b0, sel[0]};
    endfunction

    typedef struct packed {
        logic cmd;
        logic ctl;
    } chan_sel_t;

endpackage

// File: rtl/pos_store.sv
module pos_store #(
    parameter int NPOS   = 8,
    localparam int PW    = $clog2(NPOS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic [NPOS-1:0][7:0]  bytes_out
);
    import ide_cfg_pkg::*;

    logic [NPOS-1:0][7:0] bytes_d, bytes_q;

    always_comb begin
        bytes_d = bytes_q;
        if (wr_en && (wr_addr >= PW'(2)))
            bytes_d[wr_addr] = wr_data;
        bytes_d[0] = CARD_ID_LO;
        bytes_d[1] = CARD_ID_HI;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q    <= '0;
            bytes_q[0] <= CARD_ID_LO;
            bytes_q[1] <= CARD_ID_HI;
        end else begin
            bytes_q <= bytes_d;
        end
    end

    assign rd_data   = bytes_q[rd_addr];
    assign bytes_out = bytes_q;

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= PW'(2))) |=> (bytes_q[$past(wr_addr)] == $past(wr_data)));

    assert_idlo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == PW'(0))) |=> (bytes_q[0] == CARD_ID_LO));

endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
    parameter int IO_AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_en,
    input  logic             io_en,
    input  logic [1:0]       io_pick,
    input  logic             irq_en,
    input  logic [1:0]       irq_pick,
    input  logic [IO_AW-1:0] io_addr,
    output logic             cmd_cs,
    output logic             ctl_cs,
    output logic [3:0]       irq_num,
    output logic             irq_vld
);
    import ide_cfg_pkg::*;

    chan_sel_t        sel_d, sel_q;
    logic [IO_AW-1:0] base_ext, ctl_ext;
    logic             live;

    always_comb begin
        base_ext  = IO_AW'(cmd_base(io_pick));
        ctl_ext   = IO_AW'(ctl_addr(io_pick));
        live      = card_en && io_en;
        sel_d.cmd = live && (io_addr[IO_AW-1:3] == base_ext[IO_AW-1:3]);
        sel_d.ctl = live && (io_addr == ctl_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign cmd_cs  = sel_q.cmd;
    assign ctl_cs  = sel_q.ctl;
    assign irq_vld = irq_en;
    assign irq_num = irq_en ? irq_of(irq_pick) : 4'd0;

    // R5 / R7: a channel never selects both registers for one address
    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_q.cmd && sel_q.ctl));

    // R5 / R7: a disabled channel is silent on the next cycle
    assert_ioen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |=> (!cmd_cs && !ctl_cs));

    assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vld |-> (irq_num inside {4'd10, 4'd11, 4'd14, 4'd15}));

    assert_irqoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vld |-> (irq_num == 4'd0));

endmodule

// File: rtl/rom_decode.sv
module rom_decode #(
    parameter int MEM_AW   = 20,
    parameter int WIN_BITS = 14,
    parameter int ROM_BLK0 = 'h30,
    localparam int BLK_W   = MEM_AW - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_en,
    input  logic              rom_en,
    input  logic [2:0]        rom_pick,
    input  logic [MEM_AW-1:0] mem_addr,
    output logic              rom_cs
);
    localparam logic [MEM_AW-1:0] ROM_LO = MEM_AW'(ROM_BLK0) << WIN_BITS;
    localparam logic [MEM_AW-1:0] ROM_HI = MEM_AW'(ROM_BLK0 + 7) << WIN_BITS;

    logic             hit_d, hit_q;
    logic [2:0]       slot;
    logic [BLK_W-1:0] target;

    always_comb begin
        slot   = (rom_pick == 3'd7) ? 3'd6 : rom_pick;
        target = BLK_W'(ROM_BLK0) + BLK_W'(slot);
        hit_d  = card_en && rom_en && (mem_addr[MEM_AW-1:WIN_BITS] == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assign rom_cs = hit_q;

    assert_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (($past(mem_addr) >= ROM_LO) && ($past(mem_addr) < ROM_HI)));

    assert_romen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_en |=> !rom_cs);

endmodule

// File: rtl/ide_cfg_decode.sv
module ide_cfg_decode #(
    parameter int NPOS   = 8,
    parameter int IO_AW  = 16,
    parameter int MEM_AW = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [$clog2(NPOS)-1:0]  cfg_addr,
    input  logic [7:0]               cfg_wdata,
    output logic [7:0]               cfg_rdata,
    output logic                     card_on,
    input  logic [IO_AW-1:0]         io_addr,
    input  logic [MEM_AW-1:0]        mem_addr,
    output logic                     pri_cmd_cs,
    output logic                     pri_ctl_cs,
    output logic                     sec_cmd_cs,
    output logic                     sec_ctl_cs,
    output logic                     rom_cs,
    output logic [3:0]               pri_irq,
    output logic                     pri_irq_vld,
    output logic [3:0]               sec_irq,
    output logic                     sec_irq_vld
);
    import ide_cfg_pkg::*;

    localparam int NCH      = 2;
    localparam int GLOB_IDX = 2;
    localparam int CH0_IDX  = 3;

    logic [NPOS-1:0][7:0] pos;
    logic [NCH-1:0]       cmd_w, ctl_w, vld_w;
    logic [NCH-1:0][3:0]  irq_w;

    pos_store #(.NPOS(NPOS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr   (cfg_addr),
        .rd_data   (cfg_rdata),
        .bytes_out (pos)
    );

    assign card_on = pos[GLOB_IDX][CARD_EN_BIT];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_decode #(.IO_AW(IO_AW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .card_en  (card_on),
            .io_en    (pos[CH0_IDX+ch][CH_IO_EN]),
            .io_pick  (pos[CH0_IDX+ch][1:0]),
            .irq_en   (pos[CH0_IDX+ch][CH_IRQ_EN]),
            .irq_pick (pos[CH0_IDX+ch][CH_IRQ_LSB+1:CH_IRQ_LSB]),
            .io_addr  (io_addr),
            .cmd_cs   (cmd_w[ch]),
            .ctl_cs   (ctl_w[ch]),
            .irq_num  (irq_w[ch]),
            .irq_vld  (vld_w[ch])
        );
    end

    rom_decode #(.MEM_AW(MEM_AW)) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_en  (card_on),
        .rom_en   (pos[GLOB_IDX][ROM_EN_BIT]),
        .rom_pick (pos[GLOB_IDX][ROM_SEL_LSB+2:ROM_SEL_LSB]),
        .mem_addr (mem_addr),
        .rom_cs   (rom_cs)
    );

    assign pri_cmd_cs  = cmd_w[0];
    assign pri_ctl_cs  = ctl_w[0];
    assign sec_cmd_cs  = cmd_w[1];
    assign sec_ctl_cs  = ctl_w[1];
    assign pri_irq     = irq_w[0];
    assign pri_irq_vld = vld_w[0];
    assign sec_irq     = irq_w[1];
    assign sec_irq_vld = vld_w[1];

    // bits with no decode meaning
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{pos[1:0], pos[GLOB_IDX][3:1], pos[CH0_IDX][6], pos[CH0_IDX][2],
                               pos[CH0_IDX+1][6], pos[CH0_IDX+1][2], pos[NPOS-1:CH0_IDX+NCH]};

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !card_on |=> !(pri_cmd_cs || pri_ctl_cs || sec_cmd_cs || sec_ctl_cs || rom_cs));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_addr == 3'd2) && cfg_wdata[0] && !card_on) |=> !(pri_cmd_cs || sec_cmd_cs || rom_cs));

endmodule

// File: tb/test_ide_cfg_decode.sv
module test_ide_cfg_decode;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        card_on;
    logic [15:0] io_addr;
    logic [19:0] mem_addr;
    logic        pri_cmd_cs, pri_ctl_cs, sec_cmd_cs, sec_ctl_cs, rom_cs;
    logic [3:0]  pri_irq, sec_irq;
    logic        pri_irq_vld, sec_irq_vld;

    int total = 0;
    int bad   = 0;
    int mpos[8];

    always #(PER/2) clk = ~clk;

    ide_cfg_decode i_ide_cfg_decode (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .card_on(card_on),
        .io_addr(io_addr), .mem_addr(mem_addr),
        .pri_cmd_cs(pri_cmd_cs), .pri_ctl_cs(pri_ctl_cs),
        .sec_cmd_cs(sec_cmd_cs), .sec_ctl_cs(sec_ctl_cs), .rom_cs(rom_cs),
        .pri_irq(pri_irq), .pri_irq_vld(pri_irq_vld),
        .sec_irq(sec_irq), .sec_irq_vld(sec_irq_vld)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int base_of(int b);
        case (b & 3)
            0: return 'h1F0;
            1: return 'h170;
            2: return 'h1E8;
            default: return 'h168;
        endcase
    endfunction

    function automatic int ctl_of(int b);
        case (b & 3)
            0: return 'h3F6;
            1: return 'h376;
            2: return 'h3EE;
            default: return 'h36E;
        endcase
    endfunction

    function automatic int irq_model(int b);
        if ((b & 'h80) == 0) return 0;
        case ((b >> 4) & 3)
            0: return 10;
            1: return 11;
            2: return 14;
            default: return 15;
        endcase
    endfunction

    function automatic int ch_live(int ch);
        return ((mpos[2] & 1) != 0 && (mpos[3+ch] & 8) != 0) ? 1 : 0;
    endfunction

    function automatic int e_cmd(int ch, int io);
        int bs = base_of(mpos[3+ch]);
        return (ch_live(ch) != 0 && io >= bs && io < bs + 8) ? 1 : 0;
    endfunction

    function automatic int e_ctl(int ch, int io);
        return (ch_live(ch) != 0 && io == ctl_of(mpos[3+ch])) ? 1 : 0;
    endfunction

    function automatic int rom_base(int code);
        int n = (code == 7) ? 6 : code;
        return 'hC0000 + n * 'h4000;
    endfunction

    function automatic int e_rom(int mem);
        int bs = rom_base((mpos[2] >> 4) & 7);
        if ((mpos[2] & 1) == 0 || (mpos[2] & 'h80) == 0) return 0;
        return (mem >= bs && mem < bs + 'h4000) ? 1 : 0;
    endfunction

    // one bus cycle: drive at the falling edge, model the rising edge, compare after it
    task automatic cyc(bit wr, int a, int d, int io, int mem);
        int ec0, el0, ec1, el1, er;
        @(negedge clk);
        cfg_wr    = wr;
        cfg_addr  = a[2:0];
        cfg_wdata = d[7:0];
        io_addr   = io[15:0];
        mem_addr  = mem[19:0];
        ec0 = e_cmd(0, io); el0 = e_ctl(0, io);
        ec1 = e_cmd(1, io); el1 = e_ctl(1, io);
        er  = e_rom(mem);
        @(posedge clk);
        if (wr && a >= 2) mpos[a] = d & 'hFF;
        #(PER/4);
        chk("R5 primary command select", int'(pri_cmd_cs), ec0);
        chk("R5 primary control select", int'(pri_ctl_cs), el0);
        chk("R7 secondary command select", int'(sec_cmd_cs), ec1);
        chk("R7 secondary control select", int'(sec_ctl_cs), el1);
        chk("R4 rom select", int'(rom_cs), er);
        chk("R3 card enable feedback", int'(card_on), mpos[2] & 1);
        chk("R6 primary irq valid", int'(pri_irq_vld), (mpos[3] >> 7) & 1);
        chk("R6 primary irq number", int'(pri_irq), irq_model(mpos[3]));
        chk("R7 secondary irq valid", int'(sec_irq_vld), (mpos[4] >> 7) & 1);
        chk("R7 secondary irq number", int'(sec_irq), irq_model(mpos[4]));
        if (a < 2) chk("R1 identity byte", int'(cfg_rdata), mpos[a]);
        else       chk("R2 option byte readback", int'(cfg_rdata), mpos[a]);
    endtask

    task automatic bus_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        cfg_wr = 1'b0;
        @(posedge clk);
        for (int i = 2; i < 8; i++) mpos[i] = 0;
        #(PER/4);
        chk("R9 reset primary selects", int'(pri_cmd_cs | pri_ctl_cs), 0);
        chk("R9 reset secondary selects", int'(sec_cmd_cs | sec_ctl_cs), 0);
        chk("R9 reset rom select", int'(rom_cs), 0);
        chk("R9 reset card enable", int'(card_on), 0);
        chk("R9 reset irq valid", int'(pri_irq_vld | sec_irq_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    int io_list[17] = '{'h167, 'h168, 'h16F, 'h170, 'h177, 'h178, 'h1E7, 'h1E8, 'h1EF,
                        'h1F0, 'h1F7, 'h1F8, 'h36E, 'h376, 'h3EE, 'h3F6, 'h3F7};

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired R8 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        mpos[0] = 'hF1; mpos[1] = 'h71;
        for (int i = 2; i < 8; i++) mpos[i] = 0;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        io_addr = '0; mem_addr = '0;
        repeat (3) @(posedge clk);
        #(PER/4);
        chk("R9 reset selects idle", int'(pri_cmd_cs | pri_ctl_cs | sec_cmd_cs | sec_ctl_cs | rom_cs), 0);
        chk("R9 reset card off", int'(card_on), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity bytes and ignored writes
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 0, 'h55, 0, 0);
        cyc(1, 1, 'hAA, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R1 low id after write", int'(cfg_rdata), 'hF1);
        cyc(0, 1, 0, 0, 0);
        chk("R1 high id after write", int'(cfg_rdata), 'h71);

        // R3: channel and rom set up, card still off
        cyc(1, 3, 'h08, 0, 0);
        cyc(1, 4, 'h09, 0, 0);
        cyc(0, 3, 0, 'h1F0, 0);
        cyc(0, 3, 0, 'h3F6, 0);
        cyc(0, 3, 0, 'h170, 0);
        chk("R3 card off blocks secondary", int'(sec_cmd_cs), 0);

        // R8: enabling write and access in the same cycle
        cyc(1, 2, 'hA1, 'h1F0, 'hC8000);
        chk("R8 same-cycle access not selected", int'(pri_cmd_cs), 0);
        cyc(0, 2, 0, 'h1F0, 'hC8000);
        chk("R8 next-cycle access selected", int'(pri_cmd_cs), 1);
        chk("R8 next-cycle rom selected", int'(rom_cs), 1);

        // R5 / R6: primary codes, secondary parked on a different pair
        for (int s = 0; s < 4; s++) begin
            cyc(1, 4, 'h88 | ((s + 1) & 3), 0, 0);
            cyc(1, 3, 'h88 | s | (s << 4), 0, 0);
            foreach (io_list[k]) cyc(0, 3, 0, io_list[k], 0);
        end
        // R7 / R6: secondary codes, primary off, irq off on primary
        cyc(1, 3, 'h00, 0, 0);
        for (int s = 0; s < 4; s++) begin
            cyc(1, 4, 'h88 | s | ((3 - s) << 4), 0, 0);
            foreach (io_list[k]) cyc(0, 4, 0, io_list[k], 0);
        end
        // R5: channel I/O enable clear
        cyc(1, 4, 'h03, 0, 0);
        cyc(0, 4, 0, 'h168, 0);
        cyc(0, 4, 0, 'h36E, 0);
        chk("R5 channel enable clear", int'(sec_ctl_cs), 0);

        // R4: every rom code at and around its window
        for (int c = 0; c < 8; c++) begin
            int bs = rom_base(c);
            cyc(1, 2, 'h81 | (c << 4), 0, 0);
            cyc(0, 2, 0, 0, bs - 1);
            cyc(0, 2, 0, 0, bs);
            cyc(0, 2, 0, 0, bs + 'h3FFF);
            cyc(0, 2, 0, 0, bs + 'h4000);
            cyc(0, 2, 0, 0, 'hBFFFF);
            cyc(0, 2, 0, 0, 'hDC000);
        end
        cyc(1, 2, 'hF1, 0, 0);
        cyc(0, 2, 0, 0, 'hD9000);
        chk("R4 code 7 aliases 0xD8000", int'(rom_cs), 1);
        cyc(1, 2, 'h21, 0, 0);
        cyc(0, 2, 0, 0, 'hC8000);
        chk("R4 rom enable clear", int'(rom_cs), 0);

        // R2: upper bytes hold data
        for (int a = 5; a < 8; a++) cyc(1, a, 'h3C ^ a, 0, 0);
        for (int a = 2; a < 8; a++) cyc(0, a, 0, 0, 0);

        // R9: reset mid-run
        cyc(1, 3, 'h88, 0, 0);
        cyc(1, 2, 'h81, 0, 0);
        bus_reset();
        cyc(0, 3, 0, 'h1F0, 'hC0000);
        chk("R9 byte 3 cleared", int'(cfg_rdata), 0);
        cyc(0, 2, 0, 'h1F0, 'hC0000);
        chk("R9 no select after reset", int'(pri_cmd_cs | rom_cs), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule